// File: doc/BRIEF.md
# Nesting Vectored Interrupt Controller

This block collects a set of level-sensitive interrupt request lines and presents one interrupt request toward a processor core. Sixteen priority slots each pick one source line, carry an enable bit and hold a 32-bit service-routine address. Slot 0 ranks highest. The core's handler reads the vector register. That read returns the address of the winning slot and marks that slot as in service. While the slot is in service, only strictly higher slots can raise the request again. A write of any value to the same register ends service for the most recent level and brings back the level that was active before it. Levels nest through a small in-service stack.

The register bus accepts a request whenever `req_valid` is high. It never applies back-pressure, so the block has no ready pin. Every accepted request produces exactly one response: `rsp_valid` is high in the following cycle and `rsp_rdata` carries the read data. Writes respond with zero. A protection bit can restrict all register access to privileged transactions. User transactions that are dropped still receive a response, with data zero.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq` is low, the protection bit is 0, the default vector is 0, every slot control reads 0 (disabled) and no level is in service.
- R2: Each cycle with `req_valid` high yields `rsp_valid` high in the next cycle. Write responses and dropped accesses carry data 0.
- R3: Slot i's vector address sits at 0x100+4*i. Its control sits at 0x200+4*i, with bit 5 as the enable and bits 4:0 as the source line index. The default vector sits at 0x034. Unused control bits read 0.
- R4: `irq` goes high one cycle after an enabled slot's selected line is high while nothing is in service. A disabled slot never raises `irq`.
- R5: A read at 0x030 returns the vector of the lowest-numbered enabled slot whose line is high, judged on the line values of the cycle in which the read is issued.
- R6: While a slot is in service, slots of equal or lower priority do not raise `irq`. A strictly higher pending slot does.
- R7: Any write to 0x030 ends the most recent service level and restores the previous one. With nothing in service, such a write has no effect.
- R8: A read at 0x030 when no eligible slot is pending returns the default vector and leaves the service state unchanged.
- R9: A vector read taken while a slot is in service returns the higher slot and nests it, up to one level per slot.
- R10: The protection register at 0x038 holds its enable in bit 0, and its other bits read 0. Only privileged transactions can read or write it. A user read returns 0, and a user write is ignored.
- R11: While protection is enabled, user reads return 0 and user writes are ignored. A user read at 0x030 does not acknowledge anything.
- R12: While protection is disabled, user transactions read and write the registers like privileged ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_SRC | Level-sensitive interrupt request lines |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged transaction |
| req_addr | input | AW | Byte address offset within the block |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_rdata | output | DW | Read data, 0 for writes and dropped accesses |
| irq | output | 1 | Registered interrupt request to the core |

## Verification
Two functions can collide in one cycle: the vector acknowledge and a change on the request lines. The bench provokes this by raising the highest-priority slot's line in the same cycle that it issues a vector read, while a lower slot is already pending. The read must return the higher slot's vector. Afterwards `irq` must stay low, because the newly nested level masks the lower slot. A second collision puts a dropped user vector read beside a pending request. There `irq` must stay high, and a later privileged read must still find the same winner.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int SRC_SEL_W = 5;

  localparam logic [11:0] OFS_VECT     = 12'h030;
  localparam logic [11:0] OFS_DEFVEC   = 12'h034;
  localparam logic [11:0] OFS_PROT     = 12'h038;
  localparam logic [11:0] OFS_SLOT_VEC = 12'h100;
  localparam logic [11:0] OFS_SLOT_CTL = 12'h200;

  typedef struct packed {
    logic                 en;
    logic [SRC_SEL_W-1:0] src;
  } slot_ctl_t;
endpackage

// File: rtl/vic_slot_bank.sv
module vic_slot_bank
  import vic_pkg::*;
#(
  parameter int NUM_SLOT = 16,
  parameter int DW       = 32,
  parameter int AW       = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [DW-1:0]                wr_data,
  output logic [NUM_SLOT-1:0][DW-1:0]  slot_vec,
  output slot_ctl_t [NUM_SLOT-1:0]     slot_ctl
);
  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
    localparam logic [AW-1:0] VEC_A = AW'(OFS_SLOT_VEC) + AW'(4 * i);
    localparam logic [AW-1:0] CTL_A = AW'(OFS_SLOT_CTL) + AW'(4 * i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_vec[i] <= '0;
        slot_ctl[i] <= '0;
      end else if (wr_en) begin
        if (wr_addr == VEC_A) slot_vec[i] <= wr_data;
        if (wr_addr == CTL_A) slot_ctl[i] <= wr_data[SRC_SEL_W:0];
      end
    end
  end
endmodule

// File: rtl/vic_prio_resolve.sv
module vic_prio_resolve
  import vic_pkg::*;
#(
  parameter int NUM_SLOT = 16,
  parameter int NUM_SRC  = 32,
  localparam int IDX_W   = $clog2(NUM_SLOT),
  localparam int LVL_W   = $clog2(NUM_SLOT + 1)
) (
  input  logic [NUM_SRC-1:0]      src_lines,
  input  slot_ctl_t [NUM_SLOT-1:0] slot_ctl,
  input  logic [LVL_W-1:0]        top_lvl,
  output logic                    hit,
  output logic [IDX_W-1:0]        win_idx
);
  logic [NUM_SLOT-1:0] eligible;

  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_elig
    logic line_on;
    always_comb begin
      line_on = 1'b0;
      for (int s = 0; s < NUM_SRC; s++)
        if (slot_ctl[i].src == SRC_SEL_W'(s)) line_on = src_lines[s];
    end
    assign eligible[i] = slot_ctl[i].en && line_on && (LVL_W'(i) < top_lvl);
  end

  always_comb begin
    hit     = |eligible;
    win_idx = '0;
    for (int i = NUM_SLOT - 1; i >= 0; i--)
      if (eligible[i]) win_idx = IDX_W'(i);
  end
endmodule

// File: rtl/vic_svc_stack.sv
module vic_svc_stack #(
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [LVL_W-1:0] top_lvl,
  output logic [LVL_W-1:0] depth
);
  logic [IDX_W-1:0] mem [DEPTH];
  logic [LVL_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push && cnt < LVL_W'(DEPTH)) begin
      mem[IDX_W'(cnt)] <= push_idx;
      cnt <= cnt + 1'b1;
    end else if (pop && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign top_lvl = (cnt == '0) ? LVL_W'(DEPTH) : LVL_W'(mem[IDX_W'(cnt - 1'b1)]);
  assign depth   = cnt;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < LVL_W'(DEPTH)));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DW       = 32,
  parameter int AW       = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_priv,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_rdata,
  output logic               irq
);
  localparam int IDX_W = $clog2(NUM_SLOT);
  localparam int LVL_W = $clog2(NUM_SLOT + 1);
  localparam logic [AW-1:0] A_VECT = AW'(OFS_VECT);
  localparam logic [AW-1:0] A_DEFV = AW'(OFS_DEFVEC);
  localparam logic [AW-1:0] A_PROT = AW'(OFS_PROT);
  localparam logic [AW-1:0] A_SVEC = AW'(OFS_SLOT_VEC);
  localparam logic [AW-1:0] A_SCTL = AW'(OFS_SLOT_CTL);
  localparam logic [AW-1:0] SPAN   = AW'(4 * NUM_SLOT);

  logic                        prot_q;
  logic [DW-1:0]               def_vec;
  logic                        irq_q;
  logic [NUM_SLOT-1:0][DW-1:0] slot_vec;
  slot_ctl_t [NUM_SLOT-1:0]    slot_ctl;
  logic                        hit;
  logic [IDX_W-1:0]            win_idx;
  logic [LVL_W-1:0]            top_lvl;
  logic [LVL_W-1:0]            stk_depth;

  logic access_ok, wr_ok, rd_ok, vect_rd, vect_wr;
  logic [IDX_W-1:0] sel_idx;
  logic [DW-1:0]    rd_mux;

  assign access_ok = req_valid
                   && (req_priv || !prot_q)
                   && (req_priv || req_addr != A_PROT);
  assign wr_ok   = access_ok && req_write;
  assign rd_ok   = access_ok && !req_write;
  assign vect_rd = rd_ok && req_addr == A_VECT;
  assign vect_wr = wr_ok && req_addr == A_VECT;
  assign sel_idx = req_addr[IDX_W+1:2];

  vic_slot_bank #(.NUM_SLOT(NUM_SLOT), .DW(DW), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_addr(req_addr),
    .wr_data(req_wdata), .slot_vec(slot_vec), .slot_ctl(slot_ctl));

  vic_prio_resolve #(.NUM_SLOT(NUM_SLOT), .NUM_SRC(NUM_SRC)) u_resolve (
    .src_lines(irq_src), .slot_ctl(slot_ctl), .top_lvl(top_lvl),
    .hit(hit), .win_idx(win_idx));

  vic_svc_stack #(.DEPTH(NUM_SLOT)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(vect_rd && hit), .push_idx(win_idx),
    .pop(vect_wr), .top_lvl(top_lvl), .depth(stk_depth));

  always_comb begin
    rd_mux = '0;
    if (req_addr == A_VECT)
      rd_mux = hit ? slot_vec[win_idx] : def_vec;
    else if (req_addr == A_DEFV)
      rd_mux = def_vec;
    else if (req_addr == A_PROT)
      rd_mux = DW'(prot_q);
    else if (req_addr >= A_SVEC && req_addr < A_SVEC + SPAN && req_addr[1:0] == 2'b00)
      rd_mux = slot_vec[sel_idx];
    else if (req_addr >= A_SCTL && req_addr < A_SCTL + SPAN && req_addr[1:0] == 2'b00)
      rd_mux = DW'(slot_ctl[sel_idx]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q    <= 1'b0;
      def_vec   <= '0;
      irq_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      irq_q     <= hit;
      rsp_valid <= req_valid;
      rsp_rdata <= rd_ok ? rd_mux : '0;
      if (wr_ok && req_addr == A_DEFV) def_vec <= req_wdata;
      if (wr_ok && req_addr == A_PROT) prot_q  <= req_wdata[0];
    end
  end

  assign irq = irq_q;

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R10
  prot_user_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_priv && req_addr == A_PROT) |=> $stable(prot_q));

  // R11
  blocked_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_priv && prot_q && req_addr == A_VECT)
      |=> $stable(stk_depth));

  // R11
  blocked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_priv && prot_q) |=> $stable(def_vec));

  // R8
  default_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vect_rd && !hit) |=> $stable(stk_depth));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lines = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [11:0] VECT = 12'h030, DEFV = 12'h034, PROT = 12'h038;

  always #4 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(lines), .req_valid(req_valid),
    .req_write(req_write), .req_priv(req_priv), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq));

  function automatic logic [11:0] svec(int i); return 12'h100 + 12'(4 * i); endfunction
  function automatic logic [11:0] sctl(int i); return 12'h200 + 12'(4 * i); endfunction

  task automatic report(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops expected responses as they appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) report("R2 unexpected response", 32'd1, 32'd0);
      else report(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  // driver
  task automatic bus(bit wr, logic [11:0] a, logic [31:0] d, bit pv,
                     logic [31:0] exp, string tag, logic [31:0] ln);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_priv = pv;
    lines = ln;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, bit pv, logic [31:0] exp, string tag);
    bus(1'b0, a, 32'h0, pv, exp, tag, lines);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, bit pv, string tag);
    bus(1'b1, a, d, pv, 32'h0, tag, lines);
  endtask

  task automatic chk_irq(logic exp, string tag);
    @(negedge clk);
    report(tag, 32'(irq), 32'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    report("watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(DEFV, 1, 32'h0, "R1 default vector reset");
    rd(PROT, 1, 32'h0, "R1 protection reset");
    rd(sctl(0), 1, 32'h0, "R1 slot control reset");
    // R8 nothing pending, default returned
    rd(VECT, 1, 32'h0, "R8 empty vector read");

    // R3 configuration
    for (int i = 0; i < 4; i++) wr(svec(i), 32'h1000 + 32'(16 * i), 1, "R3 vec wr");
    wr(sctl(0), 32'h2C, 1, "R3 ctl wr");
    wr(sctl(1), 32'hFFFF_FFE7, 1, "R3 ctl wr");
    wr(sctl(2), 32'h23, 1, "R3 ctl wr");
    wr(sctl(3), 32'h09, 1, "R3 ctl wr");
    rd(svec(2), 1, 32'h1020, "R3 slot vector readback");
    rd(sctl(1), 1, 32'h27, "R3 control unused bits zero");
    rd(sctl(3), 1, 32'h09, "R3 control disabled slot");
    wr(DEFV, 32'hDEAD_0000, 1, "R3 defvec wr");
    rd(DEFV, 1, 32'hDEAD_0000, "R3 default vector readback");

    // R4 request generation
    lines[9] = 1'b1;
    chk_irq(1'b0, "R4 disabled slot stays silent");
    lines[3] = 1'b1;
    chk_irq(1'b1, "R4 enabled slot raises irq");

    // R5 / R6 acknowledge and masking
    rd(VECT, 1, 32'h1020, "R5 winner vector");
    chk_irq(1'b0, "R6 equal priority masked");
    wr(sctl(3), 32'h29, 1, "R6 enable lower slot");
    chk_irq(1'b0, "R6 lower priority masked");
    lines[7] = 1'b1;
    chk_irq(1'b1, "R6 higher priority raises irq");

    // R9 nesting
    rd(VECT, 1, 32'h1010, "R9 nested vector");
    chk_irq(1'b0, "R9 irq after nest");
    rd(VECT, 1, 32'hDEAD_0000, "R8 default while nested");

    // R7 end of service
    wr(VECT, 32'h0, 1, "R7 eos");
    chk_irq(1'b1, "R7 previous level restored");
    lines[7] = 1'b0;
    chk_irq(1'b0, "R7 level two still in service");
    wr(VECT, 32'h1234, 1, "R7 eos");
    chk_irq(1'b1, "R7 stack empty again");
    wr(VECT, 32'h0, 1, "R7 eos on empty");
    chk_irq(1'b1, "R7 empty eos no effect");
    rd(VECT, 1, 32'h1020, "R7 winner after empty eos");
    wr(VECT, 32'h0, 1, "R7 eos");

    // R5 same-cycle line rise and acknowledge
    bus(1'b0, VECT, 32'h0, 1, 32'h1000, "R5 same-cycle rise wins", lines | 32'h1000);
    chk_irq(1'b0, "R6 top slot masks all");
    lines[12] = 1'b0;
    wr(VECT, 32'h0, 1, "R7 eos");
    chk_irq(1'b1, "R7 pending after pop");

    // R10 protection register
    wr(PROT, 32'h1, 0, "R10 user prot wr");
    rd(PROT, 1, 32'h0, "R10 user write ignored");
    wr(PROT, 32'hFFFF_FFFF, 1, "R10 priv prot wr");
    rd(PROT, 1, 32'h1, "R10 enable bit only");
    rd(PROT, 0, 32'h0, "R10 user read zero");

    // R11 protected user access
    rd(DEFV, 0, 32'h0, "R11 user read blocked");
    wr(DEFV, 32'h1234_5678, 0, "R11 user wr");
    rd(DEFV, 1, 32'hDEAD_0000, "R11 user write ignored");
    rd(VECT, 0, 32'h0, "R11 user vector read blocked");
    chk_irq(1'b1, "R11 blocked read no ack");
    rd(VECT, 1, 32'h1020, "R11 winner unchanged");
    wr(VECT, 32'h0, 1, "R11 eos");
    wr(PROT, 32'h0, 1, "R12 prot off");

    // R12 user access allowed
    rd(DEFV, 0, 32'hDEAD_0000, "R12 user read");
    wr(DEFV, 32'h0000_5555, 0, "R12 user wr");
    rd(DEFV, 0, 32'h0000_5555, "R12 user write applied");

    repeat (2) @(negedge clk);
    report("R2 all responses seen", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule